// File: doc/BRIEF.md
# Time Base and Watchdog Interrupt Controller

This block produces a periodic time-base event and a watchdog timeout from one shared binary divider, and presents either of them on an active-low interrupt line. The line behaves as an open-drain pin: it is only ever pulled low, and otherwise it is released to an external pull-up. All of the logic runs on the system oscillator clock. When that clock comes from the fast (256 kHz) source, a 3-bit prescaler first reduces it to the 32 kHz base rate. When it comes from the 32.768 kHz source, the prescaler is bypassed.

A controller drives the block with single-cycle command strobes. These start the divider in watchdog mode or in timer mode, stop it, clear it, enable or disable the interrupt line, and load the 3-bit rate value n. The event rate is the base rate divided by 2^n. In timer mode the line is pulled low for one clock on every event. In watchdog mode a 2-bit counter counts events, and on its fourth event it sets a sticky timeout flag that holds the line low. A system-enable input freezes all counting while it is low.

Top module: `tbw_irq_ctrl`

## Requirements
- R1: After reset the interrupt is disabled: `irq_oe_o` is 0 and `irq_lvl_o` is 1 (the pin floats), and the divider is stopped.
- R2: With `src_fast_i`=1, one base tick occurs every 8 clocks. At n=0 the timer events are therefore 8 clocks apart.
- R3: With `src_fast_i`=0, every enabled clock is a base tick.
- R4: Timer events occur every 2^n base ticks, for each n from 0 to 7. In timer mode each event pulls the line low for exactly one clock, one clock after the event.
- R5: In watchdog mode, the fourth event after a watchdog clear sets the timeout flag, and the line is then held low.
- R6: The timeout flag stays set until a clear-watchdog or interrupt-disable strobe arrives. A clear-timer strobe leaves it set, and so does any amount of further counting.
- R7: The watchdog-disable strobe stops the shared divider, so no timer events and no watchdog progress occur until a watchdog-enable or timer-enable strobe.
- R8: The timer-enable strobe routes the timer events to the line instead of the timeout flag. The watchdog-enable strobe selects the flag, and either strobe starts the divider.
- R9: Clear-timer resets the prescaler and divider but keeps the watchdog event count. Clear-watchdog resets both the count and the divider.
- R10: While `sys_en_i` is 0 the prescaler, divider and watchdog count hold their values, and counting resumes when it returns to 1.
- R11: While the interrupt is disabled, `irq_oe_o` is 0. Whenever `irq_oe_o` is 1, `irq_lvl_o` is 0 (open-drain drive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sys_en_i | input | 1 | System enable; 0 freezes all counting |
| src_fast_i | input | 1 | 1 = 256 kHz source (prescaled by 8), 0 = 32 kHz source |
| wdt_dis_i | input | 1 | Strobe: stop the shared divider |
| wdt_en_i | input | 1 | Strobe: start divider, route timeout flag to the line |
| tmr_en_i | input | 1 | Strobe: start divider, route timer events to the line |
| clr_wdt_i | input | 1 | Strobe: clear watchdog count, flag, prescaler and divider |
| clr_tmr_i | input | 1 | Strobe: clear prescaler and divider only |
| irq_en_i | input | 1 | Strobe: enable the interrupt line |
| irq_dis_i | input | 1 | Strobe: disable the line and clear the timeout flag |
| rate_we_i | input | 1 | Strobe: load the rate value |
| rate_i | input | 3 | Rate value n, event period 2^n base ticks |
| irq_lvl_o | output | 1 | Level presented to the pad: 0 while pulling low, else 1 |
| irq_oe_o | output | 1 | Pad drive enable; 1 pulls the line low |

## Verification
The hardest state to reach from the ports is a timeout flag that has to survive a divider clear while the watchdog count is partly advanced. That case is what tells clear-timer apart from clear-watchdog. The stimulus uses rate 3 on the slow source, where events are 8 clocks apart. It lets exactly three events pass, issues one of the two clears, and then allows a single further event. The line must fall only after the clear-timer variant. A behavioural model in the bench, updated every clock, also follows the divider through rate changes and source switches, and every cycle of the line is compared against it.

// File: rtl/tbw_pkg.sv
package tbw_pkg;

  typedef enum logic {
    ROUTE_TIMER = 1'b0,
    ROUTE_WDT   = 1'b1
  } route_e;

endpackage

// File: rtl/tbw_divider.sv
module tbw_divider #(
  parameter int PRE_BITS = 3,
  parameter int DIV_BITS = 8,
  parameter int RATE_W   = $clog2(DIV_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_en,
  input  logic              run_en,
  input  logic              src_fast,
  input  logic              clr,
  input  logic [RATE_W-1:0] rate,
  output logic              tick_o
);

  logic                cnt_en;
  logic                base_tick;
  logic [DIV_BITS-1:0] div_q, div_d;
  logic [DIV_BITS-1:0] low_mask;

  assign cnt_en = sys_en & run_en & ~clr;

  generate
    if (PRE_BITS > 0) begin : g_pre
      logic [PRE_BITS-1:0] pre_q, pre_d;

      always_comb begin
        pre_d = pre_q;
        if (clr) begin
          pre_d = '0;
        end else if (cnt_en && src_fast) begin
          pre_d = pre_q + PRE_BITS'(1);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pre_q <= '0;
        end else begin
          pre_q <= pre_d;
        end
      end

      assign base_tick = cnt_en & (src_fast ? (&pre_q) : 1'b1);
    end else begin : g_nopre
      assign base_tick = cnt_en;
    end
  endgenerate

  always_comb begin
    low_mask = (DIV_BITS'(1) << rate) - DIV_BITS'(1);
    tick_o   = base_tick & (&(div_q | ~low_mask));
    div_d    = div_q;
    if (clr) begin
      div_d = '0;
    end else if (base_tick) begin
      div_d = div_q + DIV_BITS'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

  // R10: system disable freezes the divider
  a_r10_freeze_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_en && !clr) |=> $stable(div_q));

  // R7: a stopped divider does not advance
  a_r7_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !clr) |=> $stable(div_q));

endmodule

// File: rtl/tbw_watchdog.sv
module tbw_watchdog #(
  parameter int WDT_BITS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic wdt_mode,
  input  logic clr_wdt,
  input  logic irq_dis,
  output logic flag_o
);

  logic [WDT_BITS-1:0] wc_q, wc_d;
  logic                flag_q, flag_d;
  logic                step;

  assign step = tick & wdt_mode;

  always_comb begin
    wc_d   = wc_q;
    flag_d = flag_q;
    if (clr_wdt) begin
      wc_d = '0;
    end else if (step) begin
      wc_d = wc_q + WDT_BITS'(1);
    end
    if (clr_wdt || irq_dis) begin
      flag_d = 1'b0;
    end else if (step && (&wc_q)) begin
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wc_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      wc_q   <= wc_d;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  // R6: flag is sticky until one of its two clearing strobes
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_wdt && !irq_dis) |=> flag_q);

  // R5: flag rises only on the event that wraps the watchdog count
  a_r5_flag_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> ($past(wc_q) == {WDT_BITS{1'b1}} && $past(tick) && $past(wdt_mode)));

endmodule

// File: rtl/tbw_irq_out.sv
module tbw_irq_out (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic wdt_mode,
  input  logic irq_en,
  input  logic flag,
  output logic irq_lvl_o,
  output logic irq_oe_o
);

  logic pulse_q, pulse_d;

  assign pulse_d = tick & ~wdt_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
    end
  end

  assign irq_oe_o  = irq_en & (wdt_mode ? flag : pulse_q);
  assign irq_lvl_o = ~irq_oe_o;

  // R8: in timer routing the line only falls after a divider event
  a_r8_timer_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdt_mode && irq_oe_o) |-> $past(tick));

endmodule

// File: rtl/tbw_irq_ctrl.sv
module tbw_irq_ctrl
  import tbw_pkg::*;
#(
  parameter int PRE_BITS = 3,
  parameter int DIV_BITS = 8,
  parameter int WDT_BITS = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_en_i,
  input  logic       src_fast_i,
  input  logic       wdt_dis_i,
  input  logic       wdt_en_i,
  input  logic       tmr_en_i,
  input  logic       clr_wdt_i,
  input  logic       clr_tmr_i,
  input  logic       irq_en_i,
  input  logic       irq_dis_i,
  input  logic       rate_we_i,
  input  logic [2:0] rate_i,
  output logic       irq_lvl_o,
  output logic       irq_oe_o
);

  localparam int RATE_W = $clog2(DIV_BITS);

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  logic              run_q, run_d;
  route_e            mode_q, mode_d;
  logic              ien_q, ien_d;
  logic [RATE_W-1:0] rate_q, rate_d;
  logic              clr_any;
  logic              tick_w;
  logic              flag_w;
  logic              wdt_mode;

  always_comb begin
    run_d  = run_q;
    mode_d = mode_q;
    ien_d  = ien_q;
    rate_d = rate_q;
    if (wdt_dis_i) begin
      run_d = 1'b0;
    end else if (wdt_en_i || tmr_en_i) begin
      run_d = 1'b1;
    end
    if (wdt_en_i) begin
      mode_d = ROUTE_WDT;
    end else if (tmr_en_i) begin
      mode_d = ROUTE_TIMER;
    end
    if (irq_dis_i) begin
      ien_d = 1'b0;
    end else if (irq_en_i) begin
      ien_d = 1'b1;
    end
    if (rate_we_i) begin
      rate_d = RATE_W'(rate_i);
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      run_q  <= 1'b0;
      mode_q <= ROUTE_TIMER;
      ien_q  <= 1'b0;
      rate_q <= '0;
    end else begin
      run_q  <= run_d;
      mode_q <= mode_d;
      ien_q  <= ien_d;
      rate_q <= rate_d;
    end
  end

  assign clr_any  = clr_wdt_i | clr_tmr_i;
  assign wdt_mode = (mode_q == ROUTE_WDT);

  tbw_divider #(
    .PRE_BITS (PRE_BITS),
    .DIV_BITS (DIV_BITS),
    .RATE_W   (RATE_W)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sys_en   (sys_en_i),
    .run_en   (run_q),
    .src_fast (src_fast_i),
    .clr      (clr_any),
    .rate     (rate_q),
    .tick_o   (tick_w)
  );

  tbw_watchdog #(
    .WDT_BITS (WDT_BITS)
  ) u_wdt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tick     (tick_w),
    .wdt_mode (wdt_mode),
    .clr_wdt  (clr_wdt_i),
    .irq_dis  (irq_dis_i),
    .flag_o   (flag_w)
  );

  tbw_irq_out u_irq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick      (tick_w),
    .wdt_mode  (wdt_mode),
    .irq_en    (ien_q),
    .flag      (flag_w),
    .irq_lvl_o (irq_lvl_o),
    .irq_oe_o  (irq_oe_o)
  );

  // R11: a disabled interrupt never drives the pad
  a_r11_float_when_off: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ien_q |-> !irq_oe_o);

  // R11: drive only ever pulls low
  a_r11_open_drain: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_oe_o |-> !irq_lvl_o);

endmodule

// File: tb/tb_tbw_irq_ctrl.sv
module tb_tbw_irq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int C_WDT_DIS = 0, C_WDT_EN = 1, C_TMR_EN = 2, C_CLR_WDT = 3,
                 C_CLR_TMR = 4, C_IRQ_EN = 5, C_IRQ_DIS = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sys_en_i = 1'b0, src_fast_i = 1'b0;
  logic wdt_dis_i = 1'b0, wdt_en_i = 1'b0, tmr_en_i = 1'b0;
  logic clr_wdt_i = 1'b0, clr_tmr_i = 1'b0;
  logic irq_en_i = 1'b0, irq_dis_i = 1'b0, rate_we_i = 1'b0;
  logic [2:0] rate_i = 3'd0;
  logic irq_lvl_o, irq_oe_o;

  int nchk = 0;
  int nerr = 0;
  int cycles = 0;
  bit cmp_on = 1'b0;
  string cur_tag = "R1";

  always #(CLK_PERIOD / 2) clk = ~clk;

  tbw_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sys_en_i(sys_en_i), .src_fast_i(src_fast_i),
    .wdt_dis_i(wdt_dis_i), .wdt_en_i(wdt_en_i), .tmr_en_i(tmr_en_i),
    .clr_wdt_i(clr_wdt_i), .clr_tmr_i(clr_tmr_i), .irq_en_i(irq_en_i),
    .irq_dis_i(irq_dis_i), .rate_we_i(rate_we_i), .rate_i(rate_i),
    .irq_lvl_o(irq_lvl_o), .irq_oe_o(irq_oe_o)
  );

  // behavioural reference model
  int m_run, m_wdt, m_ien, m_rate, m_pre, m_div, m_wc, m_flag, m_pulse;
  bit clr_any, cnt, btick, tick;
  int period;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_wdt = 0; m_ien = 0; m_rate = 0; m_pre = 0;
      m_div = 0; m_wc = 0; m_flag = 0; m_pulse = 0;
    end else begin
      clr_any = clr_wdt_i || clr_tmr_i;
      cnt     = sys_en_i && (m_run != 0) && !clr_any;
      btick   = cnt && (!src_fast_i || m_pre == 7);
      period  = 1 << m_rate;
      tick    = btick && ((m_div % period) == period - 1);
      m_pulse = (tick && m_wdt == 0) ? 1 : 0;
      if (clr_wdt_i || irq_dis_i) m_flag = 0;
      else if (tick && m_wdt != 0 && m_wc == 3) m_flag = 1;
      if (clr_wdt_i) m_wc = 0;
      else if (tick && m_wdt != 0) m_wc = (m_wc + 1) % 4;
      if (clr_any) begin
        m_pre = 0; m_div = 0;
      end else begin
        if (cnt && src_fast_i) m_pre = (m_pre + 1) % 8;
        if (btick) m_div = (m_div + 1) % 256;
      end
      if (wdt_dis_i) m_run = 0; else if (wdt_en_i || tmr_en_i) m_run = 1;
      if (wdt_en_i) m_wdt = 1; else if (tmr_en_i) m_wdt = 0;
      if (irq_dis_i) m_ien = 0; else if (irq_en_i) m_ien = 1;
      if (rate_we_i) m_rate = int'(rate_i);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  int exp_oe;
  always @(negedge clk) begin
    if (cmp_on) begin
      exp_oe = (m_ien != 0 && (m_wdt != 0 ? m_flag : m_pulse) != 0) ? 1 : 0;
      chk(int'(irq_oe_o) == exp_oe, cur_tag, int'(irq_oe_o), exp_oe);
      chk(int'(irq_lvl_o) == 1 - exp_oe, "R11", int'(irq_lvl_o), 1 - exp_oe);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nerr++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(input int c);
    @(negedge clk); #1;
    case (c)
      C_WDT_DIS: wdt_dis_i = 1'b1;
      C_WDT_EN:  wdt_en_i  = 1'b1;
      C_TMR_EN:  tmr_en_i  = 1'b1;
      C_CLR_WDT: clr_wdt_i = 1'b1;
      C_CLR_TMR: clr_tmr_i = 1'b1;
      C_IRQ_EN:  irq_en_i  = 1'b1;
      default:   irq_dis_i = 1'b1;
    endcase
    @(negedge clk); #1;
    {wdt_dis_i, wdt_en_i, tmr_en_i, clr_wdt_i, clr_tmr_i, irq_en_i, irq_dis_i} = '0;
  endtask

  task automatic set_rate(input int n);
    @(negedge clk); #1;
    rate_i = 3'(n); rate_we_i = 1'b1;
    @(negedge clk); #1;
    rate_we_i = 1'b0;
  endtask

  task automatic count_oe(input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk); #2;
      if (irq_oe_o) c++;
    end
  endtask

  task automatic expect_cnt(input int n, input int exp, input string tag);
    int c;
    count_oe(n, c);
    chk(c == exp, tag, c, exp);
  endtask

  task automatic expect_oe(input bit exp, input string tag);
    @(negedge clk); #2;
    chk(irq_oe_o == exp, tag, int'(irq_oe_o), int'(exp));
  endtask

  initial begin
    idle(3); #1 rst_n = 1'b1;
    idle(4);
    // R1: reset state
    expect_oe(1'b0, "R1");
    chk(irq_lvl_o == 1'b1, "R1", int'(irq_lvl_o), 1);
    cmp_on = 1'b1;

    // R3: slow source, rate 1 then rate 0
    cur_tag = "R3";
    sys_en_i = 1'b1; src_fast_i = 1'b0;
    set_rate(1); cmd(C_CLR_TMR); cmd(C_TMR_EN); cmd(C_IRQ_EN); idle(4);
    expect_cnt(32, 16, "R3");
    set_rate(0); idle(3);
    expect_cnt(32, 32, "R3");

    // R4: sweep every rate on the slow source
    cur_tag = "R4";
    for (int n = 0; n < 8; n++) begin
      set_rate(n); idle(3);
      expect_cnt(256, 256 >> n, "R4");
    end

    // R2: fast source goes through the divide-by-8 prescaler
    cur_tag = "R2";
    src_fast_i = 1'b1;
    set_rate(0); idle(10);
    expect_cnt(64, 8, "R2");
    set_rate(3); idle(10);
    expect_cnt(512, 8, "R2");
    set_rate(7); idle(10);
    expect_cnt(2048, 2, "R2");

    // R10: system disable freezes, re-enable resumes
    cur_tag = "R10";
    src_fast_i = 1'b0; set_rate(1); idle(3);
    sys_en_i = 1'b0; idle(3);
    expect_cnt(64, 0, "R10");
    sys_en_i = 1'b1; idle(2);
    expect_cnt(64, 32, "R10");

    // R11: disabled interrupt floats
    cur_tag = "R11";
    cmd(C_IRQ_DIS); idle(2);
    expect_cnt(64, 0, "R11");
    chk(irq_lvl_o == 1'b1, "R11", int'(irq_lvl_o), 1);
    cmd(C_IRQ_EN);

    // R7: watchdog-disable stops the shared divider
    cur_tag = "R7";
    cmd(C_WDT_DIS); idle(2);
    expect_cnt(64, 0, "R7");

    // R5: fourth event in watchdog mode sets the flag
    cur_tag = "R5";
    set_rate(2); cmd(C_CLR_WDT); cmd(C_WDT_EN);
    idle(8);
    expect_oe(1'b0, "R5");
    idle(20);
    expect_oe(1'b1, "R5");

    // R6: flag sticky through counting and clear-timer, cleared by IRQ disable
    cur_tag = "R6";
    idle(200);
    expect_oe(1'b1, "R6");
    set_rate(7); cmd(C_CLR_TMR);
    expect_oe(1'b1, "R6");
    cmd(C_IRQ_DIS);
    expect_oe(1'b0, "R6");
    cmd(C_IRQ_EN); idle(4);
    expect_oe(1'b0, "R6");
    cmd(C_CLR_WDT);
    expect_oe(1'b0, "R6");

    // R9: clear-watchdog forgets the count, clear-timer keeps it
    cur_tag = "R9";
    set_rate(3); cmd(C_CLR_WDT);
    idle(28); cmd(C_CLR_WDT); idle(12);
    expect_oe(1'b0, "R9");
    cmd(C_CLR_WDT);
    idle(28); cmd(C_CLR_TMR); idle(12);
    expect_oe(1'b1, "R9");

    // R8: timer-enable reroutes events in place of the set flag
    cur_tag = "R8";
    set_rate(1); cmd(C_CLR_TMR); cmd(C_TMR_EN); idle(3);
    expect_cnt(64, 32, "R8");

    cmp_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule